// File: doc/BRIEF.md
# Pointer-Addressed UART Mode Register Bank

This block holds the two 8-bit mode registers of one serial channel behind a single bus address. A one-bit internal pointer picks which register a bus access reaches. After reset, or after a set-pointer command on the command port, the pointer selects the first mode register. Any read or write of that register moves the pointer to the second register, and it stays there until the next set-pointer command or reset. Software therefore programs both registers with two consecutive accesses to the same address.

The stored bits are decoded into named mode fields for the rest of the channel:

- From the first register: receiver flow control, receiver interrupt source, error accumulation mode, parity mode, parity sense and character length.
- From the second register: transmitter flow control, clear-to-send gating, stop length code and channel mode.

The channel mode field steers a small routing multiplexer between the serial pins, the transmitter and the receiver. It supports normal operation, automatic echo, local loopback and remote loopback.

Top module: `uart_mode_bank`

## Requirements
- R1: After synchronous reset, the pointer selects the first mode register (MODE1), both registers hold 0x00, and the channel mode is normal. With MODE1 at 0x00 the decoded character length is 5.
- R2: A command cycle (`cmd_valid`=1) with `cmd_code` equal to 4'h1 returns the pointer to MODE1. Any other command code leaves the pointer unchanged.
- R3: A bus access (`cs`=1 with `rd` or `wr`, or both) while the pointer selects MODE1 moves the pointer to MODE2.
  - When `rd` and `wr` are both set in that cycle, the pointer advances once.
  - `rdata` shows the old MODE1 value.
  - The written value is stored in MODE1.
- R4: Reads and writes while the pointer selects MODE2 leave the pointer on MODE2, so repeated accesses keep reaching MODE2.
- R5: MODE1 decodes as follows:
  - bit 7: receiver RTS control.
  - bit 6: receiver interrupt on FIFO full.
  - bit 5: block error mode.
  - bits 4:3: parity mode (00 with parity, 01 forced, 10 none, 11 multi-drop).
  - bit 2: odd parity or forced-one.
  - bits 1:0: character length, equal to 5 plus the code.
- R6: MODE2 decodes as follows:
  - bits 7:6: channel mode.
  - bit 5: transmitter RTS control.
  - bit 4: CTS enable.
  - bits 3:0: stop length code.
- R7: `rdata` equals the register the pointer selects while `cs` and `rd` are both 1, and is 0x00 otherwise.
- R8: With channel mode 00 (normal), `pin_txd` follows `tx_out` and `rx_in` follows `pin_rxd`.
- R9: With channel mode 01 (auto-echo), `pin_txd` follows `pin_rxd` and `rx_in` follows `pin_rxd`. `tx_out` is not seen.
- R10: With channel mode 10 (local loop), `rx_in` follows `tx_out` and `pin_txd` is held at 1 (mark).
- R11: With channel mode 11 (remote loop), `pin_txd` follows `pin_rxd`, `rx_in` is held at 1 (mark), and `tx_out` is not seen.
- R12: `rd` and `wr` with `cs`=0 change neither register nor the pointer.
- R13: A set-pointer command in the same cycle as a bus access wins. The pointer is on MODE1 afterwards, and the access itself goes to the register selected before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus chip select for the mode register address |
| rd | input | 1 | Bus read strobe |
| wr | input | 1 | Bus write strobe |
| wdata | input | 8 | Bus write data |
| cmd_valid | input | 1 | Command port strobe |
| cmd_code | input | 4 | Command code; 4'h1 resets the pointer |
| rdata | output | 8 | Read data of the selected register |
| rx_rts_ctl | output | 1 | Receiver drives RTS for flow control |
| rx_int_full | output | 1 | Receiver interrupt on FIFO full instead of ready |
| err_block | output | 1 | Error status accumulates over a block |
| par_mode | output | 2 | Parity mode |
| par_odd | output | 1 | Parity sense / forced bit value |
| char_bits | output | 4 | Data bits per character (5 to 8) |
| tx_rts_ctl | output | 1 | Transmitter drives RTS |
| cts_en | output | 1 | Transmitter gated by CTS |
| stop_code | output | 4 | Stop length code |
| chan_mode | output | 2 | Channel routing mode |
| pin_rxd | input | 1 | Serial receive pin |
| tx_out | input | 1 | Serial output of the transmitter |
| pin_txd | output | 1 | Serial transmit pin |
| rx_in | output | 1 | Serial input to the receiver |

## Verification
Every one of the 256 byte values is written to MODE1, and its bitwise complement pattern to MODE2. This sweep separates each decoded field from its neighbours and catches swapped or shifted bit positions in both registers.

Short access sequences then exercise the pointer:
- reads only, writes only, and read with write together;
- strobes with `cs` low;
- foreign command codes;
- a set-pointer command coinciding with an access.

Read-back values reveal which register each access reached, so an early, late or double advance shows up as the wrong byte.

All four channel modes are swept over every combination of `pin_rxd` and `tx_out`. This distinguishes a path that follows the pin, a path that follows the transmitter, and a path held at mark.

// File: rtl/mbank_pkg.sv
package mbank_pkg;

    typedef enum logic {
        PTR_MODE1 = 1'b0,
        PTR_MODE2 = 1'b1
    } ptr_e;

    typedef enum logic [1:0] {
        PAR_WITH  = 2'b00,
        PAR_FORCE = 2'b01,
        PAR_NONE  = 2'b10,
        PAR_MDROP = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'b00,
        CH_ECHO   = 2'b01,
        CH_LLOOP  = 2'b10,
        CH_RLOOP  = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic      rx_rts;
        logic      rx_int_full;
        logic      err_block;
        par_mode_e par;
        logic      par_odd;
        logic [1:0] len_code;
    } mode1_t;

    typedef struct packed {
        chan_mode_e chan;
        logic       tx_rts;
        logic       cts_en;
        logic [3:0] stop_code;
    } mode2_t;

    localparam int REG_W = $bits(mode1_t);
    localparam int MIN_CHAR_BITS = 5;

    function automatic logic [3:0] char_len(input logic [1:0] code);
        return 4'(MIN_CHAR_BITS) + {2'b00, code};
    endfunction

endpackage

// File: rtl/mbank_ptr.sv
module mbank_ptr
    import mbank_pkg::*;
#(
    parameter int CMD_W = 4,
    parameter logic [CMD_W-1:0] SET_PTR_CODE = 'h1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output ptr_e             ptr
);

    logic set_ptr;
    logic access;

    assign set_ptr = cmd_valid && (cmd_code == SET_PTR_CODE);
    assign access  = cs && (rd || wr);

    // The command wins over an access in the same cycle.
    // A combined read and write counts as one access.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= PTR_MODE1;
        end else if (set_ptr) begin
            ptr <= PTR_MODE1;
        end else if (access && ptr == PTR_MODE1) begin
            ptr <= PTR_MODE2;
        end
    end

    AST_SETPTR_TO_MODE1: assert property (@(posedge clk) disable iff (rst)
        set_ptr |=> ptr == PTR_MODE1); // R2

    AST_MODE1_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (!set_ptr && access && ptr == PTR_MODE1) |=> ptr == PTR_MODE2); // R3

    AST_MODE2_STICKS: assert property (@(posedge clk) disable iff (rst)
        (!set_ptr && ptr == PTR_MODE2) |=> ptr == PTR_MODE2); // R4

    AST_IDLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        (!set_ptr && !access) |=> $stable(ptr)); // R12

endmodule

// File: rtl/mbank_regs.sv
module mbank_regs
    import mbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ptr_e             sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output mode1_t           m1,
    output mode2_t           m2,
    output logic [REG_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            m1 <= mode1_t'('0);
            m2 <= mode2_t'('0);
        end else if (wr_en) begin
            if (sel == PTR_MODE1) begin
                m1 <= mode1_t'(wdata);
            end else begin
                m2 <= mode2_t'(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata = (sel == PTR_MODE1) ? REG_W'(m1) : REG_W'(m2);
        end
    end

    AST_MODE1_STORES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == PTR_MODE1) |=> (REG_W'(m1) == $past(wdata) && $stable(m2))); // R3

    AST_MODE2_STORES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == PTR_MODE2) |=> (REG_W'(m2) == $past(wdata) && $stable(m1))); // R4

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(m1) && $stable(m2))); // R12

endmodule

// File: rtl/mbank_router.sv
module mbank_router
    import mbank_pkg::*;
(
    input  chan_mode_e mode,
    input  logic       pin_rxd,
    input  logic       tx_out,
    output logic       pin_txd,
    output logic       rx_in
);

    localparam logic MARK = 1'b1;

    always_comb begin
        unique case (mode)
            CH_NORMAL: begin
                pin_txd = tx_out;
                rx_in   = pin_rxd;
            end
            CH_ECHO: begin
                pin_txd = pin_rxd;
                rx_in   = pin_rxd;
            end
            CH_LLOOP: begin
                pin_txd = MARK;
                rx_in   = tx_out;
            end
            default: begin
                pin_txd = pin_rxd;
                rx_in   = MARK;
            end
        endcase
    end

endmodule

// File: rtl/uart_mode_bank.sv
module uart_mode_bank
    import mbank_pkg::*;
#(
    parameter int CMD_W = 4,
    parameter logic [CMD_W-1:0] SET_PTR_CODE = 'h1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic [7:0]       rdata,
    output logic             rx_rts_ctl,
    output logic             rx_int_full,
    output logic             err_block,
    output logic [1:0]       par_mode,
    output logic             par_odd,
    output logic [3:0]       char_bits,
    output logic             tx_rts_ctl,
    output logic             cts_en,
    output logic [3:0]       stop_code,
    output logic [1:0]       chan_mode,
    input  logic             pin_rxd,
    input  logic             tx_out,
    output logic             pin_txd,
    output logic             rx_in
);

    ptr_e   ptr;
    mode1_t m1;
    mode2_t m2;

    mbank_ptr #(
        .CMD_W        (CMD_W),
        .SET_PTR_CODE (SET_PTR_CODE)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .rd        (rd),
        .wr        (wr),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .ptr       (ptr)
    );

    mbank_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .sel   (ptr),
        .wr_en (cs && wr),
        .rd_en (cs && rd),
        .wdata (wdata),
        .m1    (m1),
        .m2    (m2),
        .rdata (rdata)
    );

    mbank_router u_route (
        .mode    (m2.chan),
        .pin_rxd (pin_rxd),
        .tx_out  (tx_out),
        .pin_txd (pin_txd),
        .rx_in   (rx_in)
    );

    assign rx_rts_ctl  = m1.rx_rts;
    assign rx_int_full = m1.rx_int_full;
    assign err_block   = m1.err_block;
    assign par_mode    = m1.par;
    assign par_odd     = m1.par_odd;
    assign char_bits   = char_len(m1.len_code);
    assign tx_rts_ctl  = m2.tx_rts;
    assign cts_en      = m2.cts_en;
    assign stop_code   = m2.stop_code;
    assign chan_mode   = m2.chan;

    AST_ECHO_PATH: assert property (@(posedge clk) disable iff (rst)
        chan_mode == CH_ECHO |-> (pin_txd == pin_rxd && rx_in == pin_rxd)); // R9

    AST_LLOOP_MARK: assert property (@(posedge clk) disable iff (rst)
        chan_mode == CH_LLOOP |-> (pin_txd && rx_in == tx_out)); // R10

    AST_RLOOP_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        chan_mode == CH_RLOOP |-> (rx_in && pin_txd == pin_rxd)); // R11

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (char_bits >= 4'd5 && char_bits <= 4'd8)); // R5

endmodule

// File: tb/uart_mode_bank_bench.sv
`timescale 1ns/1ps
module uart_mode_bank_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = '0;
    logic [7:0] rdata;
    logic       rx_rts_ctl, rx_int_full, err_block, par_odd;
    logic [1:0] par_mode, chan_mode;
    logic [3:0] char_bits, stop_code;
    logic       tx_rts_ctl, cts_en;
    logic       pin_rxd = 1'b1, tx_out = 1'b1;
    logic       pin_txd, rx_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model of pointer and register contents.
    bit         mptr = 1'b0;
    logic [7:0] mm1 = '0;
    logic [7:0] mm2 = '0;

    always #2.5 clk = ~clk;

    uart_mode_bank u_uart_mode_bank (
        .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .wdata(wdata),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .rdata(rdata),
        .rx_rts_ctl(rx_rts_ctl), .rx_int_full(rx_int_full), .err_block(err_block),
        .par_mode(par_mode), .par_odd(par_odd), .char_bits(char_bits),
        .tx_rts_ctl(tx_rts_ctl), .cts_en(cts_en), .stop_code(stop_code),
        .chan_mode(chan_mode), .pin_rxd(pin_rxd), .tx_out(tx_out),
        .pin_txd(pin_txd), .rx_in(rx_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // One bus/command cycle. rdata is checked before the edge, then the model advances.
    task automatic bus(input logic c, input logic r, input logic w, input logic [7:0] d,
                       input logic cv, input logic [3:0] cc, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        cs = c; rd = r; wr = w; wdata = d; cmd_valid = cv; cmd_code = cc;
        exp = (c && r) ? (mptr ? mm2 : mm1) : 8'h00;
        #1 chk({tag, " rdata"}, 32'(rdata), 32'(exp));
        if (c && w) begin
            if (!mptr) mm1 = d; else mm2 = d;
        end
        if (cv && cc == 4'h1) mptr = 1'b0;
        else if (c && (r || w) && !mptr) mptr = 1'b1;
        @(posedge clk);
        #1;
        cs = 0; rd = 0; wr = 0; cmd_valid = 0; cmd_code = 0;
    endtask

    task automatic set_ptr(input string tag);
        bus(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 4'h1, tag);
    endtask

    task automatic chk_dec1(input string tag, input logic [7:0] v);
        chk(tag, {22'd0, rx_rts_ctl, rx_int_full, err_block, par_mode, par_odd, char_bits},
            {22'd0, v[7], v[6], v[5], v[4:3], v[2], 4'd5 + {2'b00, v[1:0]}});
    endtask

    task automatic chk_dec2(input string tag, input logic [7:0] v);
        chk(tag, {24'd0, chan_mode, tx_rts_ctl, cts_en, stop_code}, {24'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk_dec1("R1 mode1 decode after reset", 8'h00);
        chk_dec2("R1 mode2 decode after reset", 8'h00);
        pin_rxd = 1'b0; tx_out = 1'b1;
        #1 chk("R1 normal routing txd", 32'(pin_txd), 32'd1);
        chk("R1 normal routing rx", 32'(rx_in), 32'd0);
        pin_rxd = 1'b1;
        bus(1, 1, 0, 8'h00, 0, 0, "R1 first read hits MODE1");

        // R3/R4: write MODE1 then stay on MODE2
        set_ptr("R2 set");
        bus(1, 0, 1, 8'h3C, 0, 0, "R3 write MODE1");
        bus(1, 1, 0, 8'h00, 0, 0, "R3 read now MODE2");
        bus(1, 0, 1, 8'h81, 0, 0, "R4 write MODE2");
        bus(1, 1, 0, 8'h00, 0, 0, "R4 read MODE2 again");
        bus(1, 1, 0, 8'h00, 0, 0, "R4 read MODE2 third");
        chk_dec1("R5 decode 3C", 8'h3C);
        chk_dec2("R6 decode 81", 8'h81);

        // R2: foreign command ignored
        bus(0, 0, 0, 8'h00, 1, 4'h2, "R2 foreign cmd");
        bus(1, 1, 0, 8'h00, 0, 0, "R2 still MODE2 after foreign cmd");

        // R12: strobes without cs
        set_ptr("R12 set");
        bus(0, 1, 1, 8'hFF, 0, 0, "R12 strobes without cs");
        chk_dec1("R12 MODE1 untouched", 8'h3C);
        chk_dec2("R12 MODE2 untouched", 8'h81);
        bus(1, 1, 0, 8'h00, 0, 0, "R12 pointer still MODE1");
        bus(1, 1, 0, 8'h00, 0, 0, "R12 then MODE2");

        // R3: simultaneous read and write on MODE1
        set_ptr("R3 set");
        bus(1, 1, 1, 8'h5A, 0, 0, "R3 rd+wr returns old MODE1");
        chk_dec1("R3 rd+wr stored MODE1", 8'h5A);
        bus(1, 1, 0, 8'h00, 0, 0, "R3 single advance to MODE2");
        bus(1, 1, 0, 8'h00, 0, 0, "R3 MODE2 held");

        // R13: command together with access
        bus(1, 0, 1, 8'h47, 1, 4'h1, "R13 write MODE2 with set cmd");
        chk_dec2("R13 write reached MODE2", 8'h47);
        bus(1, 1, 0, 8'h00, 1, 4'h1, "R13 read MODE1 with set cmd");
        bus(1, 1, 0, 8'h00, 0, 0, "R13 pointer kept on MODE1");
        bus(1, 1, 0, 8'h00, 0, 0, "R13 now MODE2");

        // R5/R6/R7: exhaustive field sweep
        for (int v = 0; v < 256; v++) begin
            set_ptr("R7 sweep set");
            bus(1, 0, 1, 8'(v), 0, 0, "R5 sweep write MODE1");
            bus(1, 0, 1, 8'(v) ^ 8'hFF, 0, 0, "R6 sweep write MODE2");
            chk_dec1("R5 sweep decode", 8'(v));
            chk_dec2("R6 sweep decode", 8'(v) ^ 8'hFF);
            set_ptr("R7 sweep set2");
            bus(1, 1, 0, 8'h00, 0, 0, "R7 sweep read MODE1");
            bus(1, 1, 0, 8'h00, 0, 0, "R7 sweep read MODE2");
        end

        // R8..R11: routing sweep
        for (int m = 0; m < 4; m++) begin
            set_ptr("R8 route set");
            bus(1, 0, 1, 8'h00, 0, 0, "R8 route MODE1");
            bus(1, 0, 1, {2'(m), 6'h00}, 0, 0, "R8 route MODE2");
            for (int p = 0; p < 4; p++) begin
                logic exp_tx, exp_rx;
                pin_rxd = p[0];
                tx_out  = p[1];
                case (m)
                    0: begin exp_tx = p[1]; exp_rx = p[0]; end
                    1: begin exp_tx = p[0]; exp_rx = p[0]; end
                    2: begin exp_tx = 1'b1; exp_rx = p[1]; end
                    default: begin exp_tx = p[0]; exp_rx = 1'b1; end
                endcase
                #1;
                case (m)
                    0: begin
                        chk("R8 normal txd", 32'(pin_txd), 32'(exp_tx));
                        chk("R8 normal rx", 32'(rx_in), 32'(exp_rx));
                    end
                    1: begin
                        chk("R9 echo txd", 32'(pin_txd), 32'(exp_tx));
                        chk("R9 echo rx", 32'(rx_in), 32'(exp_rx));
                    end
                    2: begin
                        chk("R10 local loop txd", 32'(pin_txd), 32'(exp_tx));
                        chk("R10 local loop rx", 32'(rx_in), 32'(exp_rx));
                    end
                    default: begin
                        chk("R11 remote loop txd", 32'(pin_txd), 32'(exp_tx));
                        chk("R11 remote loop rx", 32'(rx_in), 32'(exp_rx));
                    end
                endcase
            end
        end

        // R1: reset again restores pointer and contents
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        mptr = 1'b0; mm1 = 8'h00; mm2 = 8'h00;
        chk_dec2("R1 MODE2 cleared by reset", 8'h00);
        bus(1, 1, 0, 8'h00, 0, 0, "R1 reset pointer MODE1");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule